// File: doc/BRIEF.md
# Cascaded Pulse Accumulator Counter

This block counts events seen on an external pin using two byte-wide counters. With the chain bit set, the two bytes act as one 16-bit accumulator. In that case the upper counter is the high byte, the lower counter is the low byte, and a wrap of the low byte carries into the high byte. With the chain bit clear, the upper byte counts the accumulator pin and the lower byte counts a second, auxiliary pin, and no carry passes between them.

Two counting styles are offered for the accumulator pin. In event mode, every selected edge adds one. In gated mode, a free-running internal tick adds one while the pin sits at its active level. Two sticky flags record events and drive interrupt outputs: one for the input edge and one for the high byte wrapping. Software clears a flag by writing 1 to its bit. An optional fast-clear mode clears all flags on any access to a count register.

The register bus is a plain single-cycle interface with no back-pressure. A write takes effect at the clock edge on which `bus_req` and `bus_we` are high. Read data is combinational from the current address. A word access at the high-count address moves both bytes in one cycle, so the 16-bit value stays coherent. Two separate byte accesses may see the count change between them.

Top module: `paccum_top`

## Requirements
- R1: After reset the control register, both count bytes and both flags are 0, and `irq_edge`/`irq_ovf` are low.
- R2: The control register is at address 0: bit0 chain, bits[2:1] edge select (00 none, 01 rising, 10 falling, 11 both), bit3 gated mode, bit4 gate active-high, bit5 fast clear, bit6 edge interrupt enable, bit7 overflow interrupt enable. In event mode the accumulator count advances once per selected edge.
- R3: With chain set, the accumulator pin advances the low byte, and a low-byte wrap from 0xFF to 0x00 advances the high byte in the same cycle.
- R4: With chain clear, the high byte counts accumulator-pin events and the low byte counts selected edges of `aux_pin`, with no carry from low to high.
- R5: When the high byte wraps from 0xFF to 0x00 through counting, the overflow flag (flags bit1) sets.
- R6: In gated mode the edge select is ignored for the accumulator pin. The count then advances on every TICK_DIV-th clock while the synchronised pin is at the active level (high when bit4 is 1, low when bit4 is 0).
- R7: The edge flag (flags bit0) sets on the selected edge in event mode, and on the trailing edge of the gate in gated mode; the leading gate edge does not set it.
- R8: Writing the flag register at address 1 clears each flag whose data bit is 1. Bits written 0 have no effect. A flag set in the same cycle stays set.
- R9: With fast clear set, any read or write of address 2 or 3 clears both flags. With fast clear off, such accesses leave the flags unchanged.
- R10: A word access at address 2 reads {high,low} and writes high from data[15:8] and low from data[7:0] in one cycle. A byte access at address 2 or 3 uses the high or low byte in data[7:0], and the read's upper bits are 0.
- R11: A bus write to a count byte takes priority over counting in that cycle. A written byte produces no carry and no overflow.
- R12: `irq_edge` equals edge flag AND bit6, and `irq_ovf` equals overflow flag AND bit7.
- R13: Each pin passes two synchroniser flops. A pin change set up before clock edge k is counted at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_pin | input | 1 | Accumulator input (event or gate) |
| aux_pin | input | 1 | Low-byte event input when not chained |
| bus_req | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_word | input | 1 | Word access (honoured at address 2) |
| bus_addr | input | 2 | 0 control, 1 flags, 2 count high, 3 count low |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| irq_edge | output | 1 | Edge-flag interrupt |
| irq_ovf | output | 1 | Overflow-flag interrupt |

## Verification
The hardest case to reach from the ports is a bus write to a count byte landing in the same cycle as a synchronised pin event, because the event lags the pin by two flops. The stimulus raises the pin, waits exactly two clock edges, and then holds the word write across the edge that would have counted, so only the written value survives. Flag clears that race a new setting event, and high-byte wraps reached through the carry path, are prepared by preloading the count to 0xFFFF or 0x00FE with word writes.

// File: rtl/paccum_pkg.sv
package paccum_pkg;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] A_CHI  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLO  = 2'd3;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      ovf_ie;
    logic      edge_ie;
    logic      fast_clr;
    logic      gate_high;
    logic      gated;
    edge_sel_e edge_sel;
    logic      chain;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic edge_hit(edge_sel_e sel, logic rise, logic fall);
    case (sel)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      EDGE_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/paccum_sync_edge.sv
module paccum_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sr;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sr[i] <= 1'b0;
          else        sr[i] <= sr[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= sr[STAGES-1];

  assign level = sr[STAGES-1];
  assign rise  = level & ~prev;
  assign fall  = ~level & prev;
endmodule

// File: rtl/paccum_tick.sv
module paccum_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
endmodule

// File: rtl/paccum_byte_cnt.sv
module paccum_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  assign wrap = inc & ~load & (q == MAXV);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
    else if (inc)  q <= q + 1'b1;

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d));
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(q));
endmodule

// File: rtl/paccum_flags.sv
module paccum_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_edge,
  input  logic       set_ovf,
  input  logic       clr_wr,
  input  logic [1:0] clr_mask,
  input  logic       clr_all,
  output logic       flag_edge,
  output logic       flag_ovf
);
  logic [1:0] clr;

  always_comb begin
    clr = 2'b00;
    if (clr_wr)  clr = clr | clr_mask;
    if (clr_all) clr = 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_edge <= 1'b0;
      flag_ovf  <= 1'b0;
    end else begin
      flag_edge <= (flag_edge & ~clr[0]) | set_edge;
      flag_ovf  <= (flag_ovf  & ~clr[1]) | set_ovf;
    end

  p_w1c_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_mask[0] && !set_edge) |=> !flag_edge);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_edge |=> flag_edge);
  p_fast_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !set_edge && !set_ovf) |=> (!flag_edge && !flag_ovf));
endmodule

// File: rtl/paccum_top.sv
module paccum_top #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_pin,
  input  logic                  aux_pin,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic                  bus_word,
  input  logic [1:0]            bus_addr,
  input  logic [2*BYTE_W-1:0]   bus_wdata,
  output logic [2*BYTE_W-1:0]   bus_rdata,
  output logic                  irq_edge,
  output logic                  irq_ovf
);
  import paccum_pkg::*;

  localparam int WORD_W = 2 * BYTE_W;
  localparam int NPIN   = 2;

  ctrl_t ctl;
  logic [NPIN-1:0] lvl, rise, fall;
  logic tick;
  logic acc_evt, aux_evt, trail;
  logic wr, cnt_access, ld_hi, ld_lo, word_hi;
  logic [BYTE_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic hi_inc, lo_inc, hi_wrap, lo_wrap;
  logic flag_edge, flag_ovf;

  // pin 0 is the accumulator input, pin 1 the auxiliary input
  logic [NPIN-1:0] pins;
  assign pins = {aux_pin, acc_pin};

  generate
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
      paccum_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins[p]),
        .level(lvl[p]), .rise(rise[p]), .fall(fall[p])
      );
    end
  endgenerate

  paccum_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  // event sources
  always_comb begin
    if (ctl.gated) begin
      acc_evt = tick & (lvl[0] == ctl.gate_high);
      trail   = ctl.gate_high ? fall[0] : rise[0];
    end else begin
      acc_evt = edge_hit(ctl.edge_sel, rise[0], fall[0]);
      trail   = acc_evt;
    end
    aux_evt = edge_hit(ctl.edge_sel, rise[1], fall[1]);
  end

  // bus decode
  assign wr         = bus_req & bus_we;
  assign cnt_access = bus_req & ((bus_addr == A_CHI) | (bus_addr == A_CLO));
  assign word_hi    = bus_word & (bus_addr == A_CHI);
  assign ld_hi      = wr & (bus_addr == A_CHI);
  assign ld_lo      = wr & ((bus_addr == A_CLO) | word_hi);
  assign hi_d       = word_hi ? bus_wdata[WORD_W-1:BYTE_W] : bus_wdata[BYTE_W-1:0];
  assign lo_d       = bus_wdata[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        ctl <= '0;
    else if (wr && bus_addr == A_CTRL) ctl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);

  // counters and cascade
  assign lo_inc = ctl.chain ? acc_evt : aux_evt;
  assign hi_inc = ctl.chain ? lo_wrap : acc_evt;

  paccum_byte_cnt #(.W(BYTE_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .inc(lo_inc), .load(ld_lo), .d(lo_d),
    .q(lo_q), .wrap(lo_wrap)
  );

  paccum_byte_cnt #(.W(BYTE_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .inc(hi_inc), .load(ld_hi), .d(hi_d),
    .q(hi_q), .wrap(hi_wrap)
  );

  paccum_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_edge(trail), .set_ovf(hi_wrap),
    .clr_wr(wr & (bus_addr == A_FLAG)), .clr_mask(bus_wdata[1:0]),
    .clr_all(ctl.fast_clr & cnt_access),
    .flag_edge(flag_edge), .flag_ovf(flag_ovf)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[CTRL_W-1:0] = ctl;
      A_FLAG:  bus_rdata[1:0]        = {flag_ovf, flag_edge};
      A_CHI:   bus_rdata = bus_word ? {hi_q, lo_q} : {{BYTE_W{1'b0}}, hi_q};
      default: bus_rdata[BYTE_W-1:0] = lo_q;
    endcase
  end

  assign irq_edge = flag_edge & ctl.edge_ie;
  assign irq_ovf  = flag_ovf  & ctl.ovf_ie;

  p_carry_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.chain && lo_wrap && !ld_hi) |=> hi_q == BYTE_W'($past(hi_q) + 1'b1));
  p_no_carry_unchained_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.chain && !acc_evt && !ld_hi) |=> $stable(hi_q));
  p_ovf_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wrap |=> flag_ovf);
  p_irq_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.ovf_ie |-> !irq_ovf);
endmodule

// File: tb/paccum_top_bench.sv
module paccum_top_bench;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_pin = 1'b0, aux_pin = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0, bus_word = 1'b1;
  logic [1:0] bus_addr = 2'd2;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_edge, irq_ovf;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  paccum_top u_paccum_top (
    .clk(clk), .rst_n(rst_n), .acc_pin(acc_pin), .aux_pin(aux_pin),
    .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_edge(irq_edge), .irq_ovf(irq_ovf)
  );

  // behavioural reference model
  int m_ctl, m_hi, m_lo, m_fe, m_fo, m_tick;
  int ah[$], bh[$];

  function automatic bit sel_hit(int sel, bit r, bit f);
    return (sel == 1 && r) || (sel == 2 && f) || (sel == 3 && (r || f));
  endfunction

  function automatic int model_read();
    case (bus_addr)
      2'd0: return m_ctl;
      2'd1: return m_fo * 2 + m_fe;
      2'd2: return bus_word ? m_hi * 256 + m_lo : m_hi;
      default: return m_lo;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_hi = 0; m_lo = 0; m_fe = 0; m_fo = 0; m_tick = 0;
      ah = '{0, 0, 0}; bh = '{0, 0, 0};
    end else begin
      bit a_lvl, a_r, a_f, b_r, b_f, tk, acc_e, aux_e, trail, lo_c, hi_i, ovf;
      bit wr, ldh, ldl, wh;
      int sel, clr;
      a_lvl = ah[1]; a_r = ah[1] && !ah[2]; a_f = !ah[1] && ah[2];
      b_r = bh[1] && !bh[2]; b_f = !bh[1] && bh[2];
      tk = (m_tick == DIV - 1);
      sel = (m_ctl >> 1) & 3;
      if (m_ctl & 8) begin
        acc_e = tk && (a_lvl == ((m_ctl >> 4) & 1));
        trail = (m_ctl & 16) ? a_f : a_r;
      end else begin
        acc_e = sel_hit(sel, a_r, a_f);
        trail = acc_e;
      end
      aux_e = sel_hit(sel, b_r, b_f);
      wr = bus_req && bus_we;
      wh = bus_word && bus_addr == 2;
      ldh = wr && bus_addr == 2;
      ldl = wr && (bus_addr == 3 || wh);
      lo_c = ((m_ctl & 1) ? acc_e : aux_e) && m_lo == 255 && !ldl;
      hi_i = (m_ctl & 1) ? lo_c : acc_e;
      ovf = hi_i && m_hi == 255 && !ldh;
      clr = 0;
      if (wr && bus_addr == 1) clr = bus_wdata & 3;
      if ((m_ctl & 32) && bus_req && bus_addr >= 2) clr = 3;
      if (ldh) m_hi = wh ? bus_wdata[15:8] : bus_wdata[7:0];
      else if (hi_i) m_hi = (m_hi + 1) % 256;
      if (ldl) m_lo = bus_wdata[7:0];
      else if ((m_ctl & 1) ? acc_e : aux_e) m_lo = (m_lo + 1) % 256;
      m_fe = (m_fe && !(clr & 1)) || trail;
      m_fo = (m_fo && !(clr & 2)) || ovf;
      if (wr && bus_addr == 0) m_ctl = bus_wdata[7:0];
      m_tick = tk ? 0 : m_tick + 1;
      ah.push_front(acc_pin); void'(ah.pop_back());
      bh.push_front(aux_pin); void'(bh.pop_back());
    end
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      checks++;
      if (int'(bus_rdata) != model_read() || irq_edge != ((m_ctl >> 6) & m_fe)
          || irq_ovf != ((m_ctl >> 7) & m_fo)) begin
        errors++;
        $display("FAIL R10 model compare: rdata=%h irq=%b%b expected rdata=%h irq=%b%b",
                 bus_rdata, irq_edge, irq_ovf, model_read(),
                 1'((m_ctl >> 6) & m_fe), 1'((m_ctl >> 7) & m_fo));
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, bit w, int d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 2'(a); bus_word = w; bus_wdata = 16'(d);
    @(negedge clk);
    bus_req = 0; bus_we = 0; bus_addr = 2'd2; bus_word = 1;
  endtask

  task automatic rd_chk(int a, bit w, int exp, string req);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 2'(a); bus_word = w;
    #1 check(req, int'(bus_rdata), exp);
    @(negedge clk);
    bus_req = 0; bus_addr = 2'd2; bus_word = 1;
  endtask

  task automatic pulse(bit on_a, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (on_a) acc_pin = 1; else aux_pin = 1;
      repeat (2) @(negedge clk);
      if (on_a) acc_pin = 0; else aux_pin = 0;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk(0, 0, 0, "R1 ctrl");
    rd_chk(2, 1, 0, "R1 count");
    rd_chk(1, 0, 0, "R1 flags");
    check("R1 irqs", {irq_edge, irq_ovf}, 0);

    // R2/R7/R12 rising edges chained
    wr_reg(0, 0, 'hC3);
    pulse(1, 3);
    rd_chk(2, 1, 3, "R2 rising count");
    rd_chk(1, 0, 1, "R7 edge flag");
    check("R12 irq_edge", irq_edge, 1);
    // R8 write-one-to-clear
    wr_reg(1, 0, 0);
    rd_chk(1, 0, 1, "R8 zero write no effect");
    wr_reg(1, 0, 1);
    rd_chk(1, 0, 0, "R8 w1c edge");
    // R2 falling, both, none
    wr_reg(0, 0, 'hC5); wr_reg(2, 1, 0); pulse(1, 2);
    rd_chk(2, 1, 2, "R2 falling count");
    wr_reg(0, 0, 'hC7); wr_reg(2, 1, 0); pulse(1, 2);
    rd_chk(2, 1, 4, "R2 both count");
    wr_reg(0, 0, 'hC1); wr_reg(2, 1, 0); wr_reg(1, 0, 3); pulse(1, 2);
    rd_chk(2, 1, 0, "R2 none count");
    rd_chk(1, 0, 0, "R7 no flag when disabled");

    // R3 carry, R10 byte access
    wr_reg(0, 0, 'hC3); wr_reg(2, 1, 'h00FE); pulse(1, 3);
    rd_chk(2, 1, 'h0101, "R3 carry into high");
    rd_chk(2, 0, 'h0001, "R10 byte high");
    rd_chk(3, 0, 'h0001, "R10 byte low");
    // R5 overflow
    wr_reg(2, 1, 'hFFFF); wr_reg(1, 0, 3); pulse(1, 1);
    rd_chk(2, 1, 0, "R5 wrap to zero");
    rd_chk(1, 0, 3, "R5 overflow flag");
    check("R12 irq_ovf", irq_ovf, 1);
    wr_reg(1, 0, 2);
    rd_chk(1, 0, 1, "R8 w1c overflow only");

    // R4 unchained
    wr_reg(0, 0, 'hC2); wr_reg(1, 0, 3); wr_reg(2, 1, 'hFFFF);
    pulse(0, 1);
    rd_chk(2, 1, 'hFF00, "R4 no carry unchained");
    rd_chk(1, 0, 0, "R4 no overflow from low");
    pulse(1, 1);
    rd_chk(2, 1, 0, "R4 high counts acc pin");
    rd_chk(1, 0, 3, "R5 overflow unchained");

    // R13 latency
    wr_reg(0, 0, 'h03); wr_reg(2, 1, 0);
    @(negedge clk); acc_pin = 1;
    @(negedge clk); #1 check("R13 after 1 edge", int'(bus_rdata), 0);
    @(negedge clk); #1 check("R13 after 2 edges", int'(bus_rdata), 0);
    @(negedge clk); #1 check("R13 after 3 edges", int'(bus_rdata), 1);
    acc_pin = 0; repeat (4) @(negedge clk);

    // R6/R7 gated active-high
    wr_reg(0, 0, 'h59); wr_reg(2, 1, 0); wr_reg(1, 0, 3);
    @(negedge clk); acc_pin = 1;
    repeat (5) @(negedge clk);
    rd_chk(1, 0, 0, "R7 leading gate edge ignored");
    repeat (33) @(negedge clk);
    acc_pin = 0; repeat (6) @(negedge clk);
    rd_chk(2, 1, 10, "R6 gated high ticks");
    rd_chk(1, 0, 1, "R7 trailing gate edge");
    // R6 gated active-low, edge select set but ignored
    acc_pin = 1; repeat (4) @(negedge clk);
    wr_reg(0, 0, 'h4F); wr_reg(2, 1, 0); wr_reg(1, 0, 3);
    @(negedge clk); acc_pin = 0;
    repeat (20) @(negedge clk);
    acc_pin = 1; repeat (6) @(negedge clk);
    rd_chk(2, 1, 5, "R6 gated low ticks");
    rd_chk(1, 0, 1, "R7 trailing rising edge");

    // R9 fast clear
    wr_reg(0, 0, 'h03);
    rd_chk(3, 0, 5, "R9 read low");
    rd_chk(1, 0, 1, "R9 no clear when off");
    wr_reg(0, 0, 'h23);
    rd_chk(3, 0, 5, "R9 read low fast");
    rd_chk(1, 0, 0, "R9 cleared by read");
    pulse(1, 1);
    wr_reg(3, 0, 7);
    rd_chk(1, 0, 0, "R9 cleared by write");

    // R11 write wins over a coincident count
    wr_reg(0, 0, 'h03); wr_reg(2, 1, 'h0010);
    @(negedge clk); acc_pin = 1;
    @(negedge clk);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 2; bus_word = 1; bus_wdata = 16'h1234;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    acc_pin = 0; repeat (4) @(negedge clk);
    rd_chk(2, 1, 'h1234, "R11 write wins");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule